// File: doc/BRIEF.md
# Separate-to-Multiplexed Bus Bridge

This block lets a host processor with separate address and data buses reach a peripheral whose 8-bit bus carries both register addresses and data. The peripheral occupies two adjacent locations in the host's 16-bit address space. The upper fifteen host address bits pick the pair. The lowest bit picks the kind of peripheral cycle: an even address gives a register-select (address) phase, and an odd address gives a data phase.

Software selects a peripheral register by writing its index to the even location. It then reads or writes the odd location to move the data. Every host request that is accepted runs a fixed sequence on the system clock: one setup clock, a strobe that lasts a programmable number of clocks, one hold clock, and then a return to idle. A ready output tells the host when a new request can be taken.

The peripheral side has four control outputs: an active-low chip select, an active-high address-latch strobe, and active-low read and write strobes. The shared byte bus is presented as three signals: a separate output, an output enable and an input.

Top module: `sepmux_bridge`

## Requirements
- R1: A request is accepted only when `host_addr[15:1]` equals the `BASE_HI` parameter and `host_ready` is 1. Any other request leaves every peripheral pin and `host_ready` unchanged.
- R2: `per_cs_n` is 0 for the whole of an accepted access, for both values of `host_addr[0]`. It is 1 whenever `host_ready` is 1, and no strobe is active unless it is 0.
- R3: An access with `host_addr[0]`=0 is an address phase. `per_ale` is 1 for exactly `STROBE_CLKS` clocks, and `per_rd_n` and `per_wr_n` stay 1 for the whole access.
- R4: In an address phase, `ad_oe` is 1 and `ad_out` carries the host write data from one clock before `per_ale` rises until one clock after it falls.
- R5: A write with `host_addr[0]`=1 pulses `per_wr_n` low for exactly `STROBE_CLKS` clocks while `per_ale` stays 0. The write data is driven with `ad_oe`=1 throughout the strobe and for one clock after it.
- R6: A read with `host_addr[0]`=1 pulses `per_rd_n` low for exactly `STROBE_CLKS` clocks with `ad_oe`=0. `host_rdata` then holds the `ad_in` value seen in the last clock before `per_rd_n` rises.
- R7: After an accepted request, `host_ready` and `per_cs_n` are both 0 for exactly `STROBE_CLKS`+2 clocks, starting at the clock edge that accepts the request.
- R8: A read of the even location performs no peripheral read. It sets `host_rdata` to 0 and still issues the `per_ale` pulse.
- R9: After a synchronous reset, `per_cs_n`, `per_rd_n` and `per_wr_n` are 1, `per_ale` is 0, `ad_oe` is 0 and `host_ready` is 1.
- R10: A request raised while `host_ready` is 0 is ignored. The running access completes unchanged and no further access follows it.
- R11: If `host_wr` and `host_rd` are both 1, the request is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 16 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read request, sampled when ready |
| host_wr | input | 1 | Host write request, sampled when ready |
| host_rdata | output | 8 | Result of the last read |
| host_ready | output | 1 | 1 when idle and able to accept a request |
| per_cs_n | output | 1 | Peripheral chip select, active low |
| per_ale | output | 1 | Peripheral address latch strobe, active high |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| ad_out | output | 8 | Value driven onto the shared byte bus |
| ad_oe | output | 1 | Output enable for the shared byte bus |
| ad_in | input | 8 | Value read back from the shared byte bus |

## Verification
The assertions assume that the host raises a request only as a single-clock pulse while `host_ready` is 1. They also assume that `host_addr` and `host_wdata` are stable in that clock. The directed tasks drive every request on the falling clock edge for exactly one clock. The only request made while busy is the one that deliberately checks that busy requests are ignored. A bench model of the peripheral latches the register index on the falling edge of the latch strobe, stores data on the rising write strobe, and drives `ad_in` from its register array. Its only other value is a fixed filler while the read strobe is high, which keeps the input from floating.

// File: rtl/sepmux_pkg.sv
package sepmux_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_STRB  = 2'd2,
    SQ_HOLD  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sepmux_decode.sv
module sepmux_decode #(
  parameter int AW = 16,
  parameter logic [AW-2:0] BASE_HI = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic          data_phase
);
  always_comb begin
    hit        = (addr[AW-1:1] == BASE_HI);
    data_phase = addr[0];
  end
endmodule

// File: rtl/sepmux_seq.sv
module sepmux_seq
  import sepmux_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ev_start,
  output logic ev_on,
  output logic ev_off,
  output logic ev_end,
  output logic idle
);
  localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(STROBE_CLKS - 1);

  seq_state_t state;
  logic [CW-1:0] cnt;

  always_comb begin
    ev_start = (state == SQ_IDLE) && start;
    ev_on    = (state == SQ_SETUP);
    ev_off   = (state == SQ_STRB) && (cnt == '0);
    ev_end   = (state == SQ_HOLD);
    idle     = (state == SQ_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE:  if (start) state <= SQ_SETUP;
        SQ_SETUP: begin
          state <= SQ_STRB;
          cnt   <= CNT_LOAD;
        end
        SQ_STRB:  if (cnt == '0) state <= SQ_HOLD;
                  else cnt <= cnt - 1'b1;
        default:  state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sepmux_pins.sv
module sepmux_pins #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_start,
  input  logic          ev_on,
  input  logic          ev_off,
  input  logic          ev_end,
  input  logic          req_data,
  input  logic          req_wr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_in,
  output logic          cs_n,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [DW-1:0] rdata
);
  logic is_data;
  logic is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_data <= 1'b0;
      is_wr   <= 1'b0;
      cs_n    <= 1'b1;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      bus_out <= '0;
      bus_oe  <= 1'b0;
      rdata   <= '0;
    end else begin
      if (ev_start) begin
        is_data <= req_data;
        is_wr   <= req_wr;
        cs_n    <= 1'b0;
        bus_out <= req_wdata;
        bus_oe  <= !req_data || req_wr;
        if (!req_data && !req_wr) rdata <= '0;
      end
      if (ev_on) begin
        if (!is_data)    ale  <= 1'b1;
        else if (is_wr)  wr_n <= 1'b0;
        else             rd_n <= 1'b0;
      end
      if (ev_off) begin
        ale  <= 1'b0;
        rd_n <= 1'b1;
        wr_n <= 1'b1;
        if (is_data && !is_wr) rdata <= bus_in;
      end
      if (ev_end) begin
        cs_n   <= 1'b1;
        bus_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sepmux_bridge.sv
module sepmux_bridge #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-2:0] BASE_HI = 15'h6000,
  parameter int STROBE_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  input  logic          host_wr,
  output logic [DW-1:0] host_rdata,
  output logic          host_ready,
  output logic          per_cs_n,
  output logic          per_ale,
  output logic          per_rd_n,
  output logic          per_wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);
  logic hit, data_phase, start;
  logic ev_start, ev_on, ev_off, ev_end;

  sepmux_decode #(.AW(AW), .BASE_HI(BASE_HI)) u_decode (
    .addr(host_addr), .hit(hit), .data_phase(data_phase)
  );

  assign start = hit && (host_rd || host_wr);

  sepmux_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .ev_start(ev_start), .ev_on(ev_on), .ev_off(ev_off), .ev_end(ev_end),
    .idle(host_ready)
  );

  sepmux_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst),
    .ev_start(ev_start), .ev_on(ev_on), .ev_off(ev_off), .ev_end(ev_end),
    .req_data(data_phase), .req_wr(host_wr), .req_wdata(host_wdata),
    .bus_in(ad_in),
    .cs_n(per_cs_n), .ale(per_ale), .rd_n(per_rd_n), .wr_n(per_wr_n),
    .bus_out(ad_out), .bus_oe(ad_oe), .rdata(host_rdata)
  );

  // R2: idle implies the peripheral is deselected
  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> per_cs_n) else $error("idle with chip select active");

  // R2: any strobe requires chip select
  p_strobe_needs_cs_r2: assert property (@(posedge clk) disable iff (rst)
    (per_ale || !per_rd_n || !per_wr_n) |-> !per_cs_n) else $error("strobe without select");

  // R3: the latch strobe only with both data strobes high
  p_ale_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    per_ale |-> (per_rd_n && per_wr_n)) else $error("latch strobe with data strobe");

  // R4: the address is driven before the latch strobe rises
  p_addr_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(per_ale) |-> $past(ad_oe)) else $error("address setup");

  // R4: the address is still driven after the latch strobe falls
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(per_ale) |-> ad_oe) else $error("address hold");

  // R5: write data is driven while the write strobe is low
  p_write_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !per_wr_n |-> ad_oe) else $error("write not driven");

  // R5: write data is still driven one clock after the write strobe rises
  p_write_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(per_wr_n) |-> ad_oe) else $error("write hold");

  // R6: the bus is released during a read, and the two data strobes are never low together
  p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
    !per_rd_n |-> (!ad_oe && per_wr_n)) else $error("read bus conflict");
endmodule

// File: tb/test_sepmux_bridge.sv
module test_sepmux_bridge;
  localparam int N = 3;
  localparam logic [14:0] BASE = 15'h6000;
  localparam logic [15:0] A_LO = {BASE, 1'b0};
  localparam logic [15:0] A_HI = {BASE, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_rdata, ad_out, ad_in;
  logic host_ready, per_cs_n, per_ale, per_rd_n, per_wr_n, ad_oe;

  int checks = 0, fails = 0;

  // measurements of one access window
  int c_busy, c_cs, c_ale, c_rd, c_wr, c_oe, c_timing_bad;

  // peripheral model
  logic [7:0] mem [256];
  logic [7:0] m_idx = '0;
  int m_bad = 0;

  always #10 clk = ~clk;

  sepmux_bridge #(.BASE_HI(BASE), .STROBE_CLKS(N)) i_sepmux_bridge (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .host_ready(host_ready), .per_cs_n(per_cs_n), .per_ale(per_ale),
    .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in)
  );

  always @(negedge per_ale) begin
    if (per_rd_n && per_wr_n && ad_oe && !per_cs_n) m_idx = ad_out;
    else m_bad++;
  end

  always @(posedge per_wr_n) begin
    if (!per_cs_n && ad_oe) mem[m_idx] = ad_out;
  end

  assign ad_in = !per_rd_n ? mem[m_idx] : 8'hA5;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one-clock request, then observe a fixed window at falling edges;
  // optional second request (busy) after `late` clocks
  task automatic access(input logic [15:0] a, input logic w, input logic r,
                        input logic [7:0] d, input int late,
                        input logic [15:0] a2);
    logic p_ale, p_oe, p_wr;
    c_busy = 0; c_cs = 0; c_ale = 0; c_rd = 0; c_wr = 0; c_oe = 0; c_timing_bad = 0;
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = w; host_rd = r;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    p_ale = per_ale; p_oe = ad_oe; p_wr = per_wr_n;
    for (int i = 0; i < N + 8; i++) begin
      if (!host_ready) c_busy++;
      if (!per_cs_n) c_cs++;
      if (per_ale) c_ale++;
      if (!per_rd_n) c_rd++;
      if (!per_wr_n) c_wr++;
      if (ad_oe) c_oe++;
      if (per_ale && !p_ale && !p_oe) c_timing_bad++;
      if (!per_ale && p_ale && !ad_oe) c_timing_bad++;
      if (per_wr_n && !p_wr && !ad_oe) c_timing_bad++;
      p_ale = per_ale; p_oe = ad_oe; p_wr = per_wr_n;
      if (i == late) begin
        host_addr = a2; host_rd = 1'b1;
      end else begin
        host_rd = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R9 cs_n", per_cs_n, 1);
    check("R9 ale", per_ale, 0);
    check("R9 rd_n", per_rd_n, 1);
    check("R9 wr_n", per_wr_n, 1);
    check("R9 oe", ad_oe, 0);
    check("R9 ready", host_ready, 1);
  endtask

  task automatic t_select(input logic [7:0] idx);
    access(A_LO, 1'b1, 1'b0, idx, -1, '0);
    check("R3 ale clocks", c_ale, N);
    check("R3 rd/wr quiet", c_rd + c_wr, 0);
    check("R2 cs clocks", c_cs, N + 2);
    check("R7 busy clocks", c_busy, N + 2);
    check("R4 setup/hold", c_timing_bad, 0);
    check("R4 oe clocks", c_oe, N + 2);
    check("R4 latched index", m_idx, idx);
  endtask

  task automatic t_write(input logic [7:0] idx, input logic [7:0] v);
    t_select(idx);
    access(A_HI, 1'b1, 1'b0, v, -1, '0);
    check("R5 wr clocks", c_wr, N);
    check("R5 ale quiet", c_ale, 0);
    check("R5 hold", c_timing_bad, 0);
    check("R5 oe clocks", c_oe, N + 2);
    check("R5 stored", mem[idx], v);
  endtask

  task automatic t_read(input logic [7:0] idx);
    t_select(idx);
    access(A_HI, 1'b0, 1'b1, 8'h00, -1, '0);
    check("R6 rd clocks", c_rd, N);
    check("R6 released", c_oe, 0);
    check("R6 rdata", host_rdata, mem[idx]);
    check("R7 busy read", c_busy, N + 2);
  endtask

  task automatic t_select_read;
    access(A_LO, 1'b0, 1'b1, 8'h11, -1, '0);
    check("R8 rdata zero", host_rdata, 0);
    check("R8 ale pulse", c_ale, N);
    check("R8 no bus read", c_rd, 0);
  endtask

  task automatic t_miss;
    access({15'h1234, 1'b1}, 1'b1, 1'b0, 8'h77, -1, '0);
    check("R1 miss cs", c_cs, 0);
    check("R1 miss busy", c_busy, 0);
    check("R1 miss strobes", c_ale + c_rd + c_wr + c_oe, 0);
  endtask

  task automatic t_busy_ignore;
    // second request (select-read of the even location) raised while busy
    t_select(8'h20);
    access(A_HI, 1'b1, 1'b0, 8'h99, 1, A_LO);
    check("R10 single access", c_busy, N + 2);
    check("R10 no ale", c_ale, 0);
    check("R10 data stored", mem[8'h20], 8'h99);
  endtask

  task automatic t_both;
    t_select(8'h31);
    access(A_HI, 1'b1, 1'b1, 8'h5C, -1, '0);
    check("R11 write wins", c_wr, N);
    check("R11 no read", c_rd, 0);
    check("R11 stored", mem[8'h31], 8'h5C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h3C);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(8'h05, 8'hC3);
    t_write(8'hFF, 8'h00);
    t_read(8'h05);
    t_read(8'h80);
    t_select_read();
    t_miss();
    t_busy_ignore();
    t_both();
    check("R4 model latch order", m_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule